// File: doc/BRIEF.md
# Sine-Modulated PWM Generator

This block turns a fixed sine waveform into a one-bit pulse-width-modulated stream. An internal counter divides time into periods of 2^CNT_W clocks. Each period the output rises at the start and falls after a number of clocks equal to one sample of an internal sine table. A table pointer steps once per period, so a full sine cycle takes one period for each table entry. With the default 8-bit settings and a 32 MHz clock, the PWM rate is 125 kHz and the sine repeats at about 488 Hz once the stream passes through an external low-pass filter.

Each period's duty value is prefetched into a shadow register. It is moved into the active compare register only at the period boundary, so a period never sees a half-updated threshold. A strobe marks the last clock of every period. The index output names the table entry that sets the duty of the period now running. Enable pauses the generator without losing its place in the waveform.

Top module: `sinpwm_gen`

## Requirements
- R1: While `en` is high the period counter steps 0,1,...,255 and wraps to 0, so one period is 256 clocks. `period_stb_o` is high for exactly the one clock in which the count is 255, and is low whenever `en` is low.
- R2: The output is active-high and is registered. It goes high in the clock after count 0 and stays high for exactly C clocks of the period, where C is the active compare value.
- R3: Clear takes priority over set. A compare value of 0 keeps the output low for the whole period, and a value of 255 gives 255 high clocks out of 256.
- R4: The active compare value changes only at the period boundary. `sample_idx_o` is constant for the whole period, and the high time of that period equals table entry `sample_idx_o`.
- R5: Table entry i equals floor(127.5 + 127.5·sin(2πi/256) + 0.5). So entry 0 is 128, entry 64 is 255 and entry 192 is 0.
- R6: The index steps by one at each period boundary, modulo 256. After index 255 comes index 0, with no sample skipped or repeated.
- R7: While `en` is low, the index holds, the counter is held at 0 and `period_stb_o` is low. The output is low from the first clock edge after `en` falls.
- R8: When `en` rises again, a new period starts at count 0. Its first strobe comes 255 clocks after the first enabled edge, and its high time equals the entry at the held index.
- R9: After reset the output and strobe are low and the index is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| en | input | 1 | Run enable; low pauses the generator |
| pwm_o | output | 1 | Pulse-width-modulated output, active-high |
| period_stb_o | output | 1 | High on the last clock of every period |
| sample_idx_o | output | IDX_W | Table index that sets the duty of the current period |

## Verification
The assertions assume that `en` changes only between clock edges and does not glitch. They hold whether `en` falls in the middle of a period or at its end. The bench drives `en` on falling clock edges only. It drops `en` in the middle of a period, well away from a wrap, so that both the paused state and the restart path are exercised. The checks cover a full sweep past index 255, which reaches entries 64 and 192, the extremes of the table.

// File: rtl/sinpwm_pkg.sv
package sinpwm_pkg;

  // Sine sample for entry i of a table with 'depth' entries and 'width' bits.
  // Uses quarter-wave folding and a Taylor series, so it is constant-evaluable.
  function automatic int sine_sample(input int i, input int depth, input int width);
    real full_s;
    real half_s;
    real x;
    real term;
    real s;
    real v;
    int  q;
    int  half_d;
    int  quart_d;
    bit  neg;
    full_s  = real'((1 << width) - 1);
    half_s  = full_s / 2.0;
    half_d  = depth / 2;
    quart_d = depth / 4;
    q       = i % depth;
    neg     = 1'b0;
    if (q >= half_d) begin
      neg = 1'b1;
      q   = q - half_d;
    end
    if (q > quart_d) q = half_d - q;
    x    = 2.0 * 3.14159265358979323846 * real'(q) / real'(depth);
    term = x;
    s    = x;
    for (int k = 1; k < 14; k++) begin
      term = -term * x * x / real'((2 * k) * (2 * k + 1));
      s    = s + term;
    end
    if (neg) s = -s;
    v = half_s + half_s * s + 0.5 + 1.0e-9;
    if (v < 0.0) v = 0.0;
    if (v > full_s) v = full_s;
    return $rtoi(v);
  endfunction

endpackage

// File: rtl/sinpwm_rst_sync.sv
module sinpwm_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n_o
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sync_q <= '0;
    else         sync_q <= sync_d;
  end

  assign srst_n_o = sync_q[STAGES-1];

endmodule

// File: rtl/sinpwm_period_ctr.sv
module sinpwm_period_ctr #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  output logic [CNT_W-1:0] cnt_o,
  output logic             wrap_o
);

  localparam logic [CNT_W-1:0] LIMIT = {CNT_W{1'b1}};

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;

  always_comb begin
    if (en) cnt_d = cnt_q + 1'b1;
    else    cnt_d = '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign cnt_o  = cnt_q;
  assign wrap_o = en && (cnt_q == LIMIT);

  // R1: counter advances by one (modulo) every enabled clock
  a_r1_count_step: assert property (@(posedge clk) disable iff (!rst_n)
    en |=> cnt_q == CNT_W'($past(cnt_q) + 1'b1));

  // R7: counter parked at zero while paused
  a_r7_count_parked: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> cnt_q == '0);

endmodule

// File: rtl/sinpwm_sine_rom.sv
module sinpwm_sine_rom
  import sinpwm_pkg::*;
#(
  parameter int IDX_W = 8,
  parameter int SMP_W = 8
) (
  input  logic [IDX_W-1:0] addr_a,
  input  logic [IDX_W-1:0] addr_b,
  output logic [SMP_W-1:0] data_a,
  output logic [SMP_W-1:0] data_b
);

  localparam int DEPTH = 1 << IDX_W;

  logic [SMP_W-1:0] table_w [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_entry
    localparam int VAL = sine_sample(g, DEPTH, SMP_W);
    assign table_w[g] = SMP_W'(VAL);
  end

  assign data_a = table_w[addr_a];
  assign data_b = table_w[addr_b];

endmodule

// File: rtl/sinpwm_duty_ctl.sv
module sinpwm_duty_ctl
  import sinpwm_pkg::*;
#(
  parameter int CNT_W = 8,
  parameter int IDX_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic [CNT_W-1:0] cnt,
  input  logic             wrap,
  input  logic [CNT_W-1:0] rom_a_data,
  input  logic [CNT_W-1:0] rom_b_data,
  output logic [IDX_W-1:0] rom_a_addr,
  output logic [IDX_W-1:0] rom_b_addr,
  output logic [IDX_W-1:0] idx_o,
  output logic             pwm_o
);

  localparam int               DEPTH   = 1 << IDX_W;
  localparam logic [CNT_W-1:0] ACT_RST = CNT_W'(sine_sample(0, DEPTH, CNT_W));
  localparam logic [CNT_W-1:0] SHD_RST = CNT_W'(sine_sample(1, DEPTH, CNT_W));

  logic [IDX_W-1:0] idx_q, idx_d;
  logic [CNT_W-1:0] act_q, act_d;
  logic [CNT_W-1:0] shd_q, shd_d;
  logic             pwm_q, pwm_d;

  // Port A: next-but-one sample while running, current sample while idle.
  // Port B: the sample after the current one (idle prefetch of the shadow).
  assign rom_a_addr = en ? IDX_W'(idx_q + IDX_W'(2)) : idx_q;
  assign rom_b_addr = IDX_W'(idx_q + 1'b1);

  always_comb begin
    idx_d = idx_q;
    act_d = act_q;
    shd_d = shd_q;
    pwm_d = pwm_q;
    if (!en) begin
      act_d = rom_a_data;
      shd_d = rom_b_data;
      pwm_d = 1'b0;
    end else begin
      if (cnt == act_q)    pwm_d = 1'b0;
      else if (cnt == '0)  pwm_d = 1'b1;
      if (wrap) begin
        act_d = shd_q;
        shd_d = rom_a_data;
        idx_d = IDX_W'(idx_q + 1'b1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q <= '0;
      act_q <= ACT_RST;
      shd_q <= SHD_RST;
      pwm_q <= 1'b0;
    end else begin
      idx_q <= idx_d;
      act_q <= act_d;
      shd_q <= shd_d;
      pwm_q <= pwm_d;
    end
  end

  assign idx_o = idx_q;
  assign pwm_o = pwm_q;

  // R2: nonzero compare means the output rises after count 0
  a_r2_set_at_start: assert property (@(posedge clk) disable iff (!rst_n)
    en && cnt == '0 && act_q != '0 |=> pwm_q);

  // R3: match clears the output, also on the starting count
  a_r3_clear_on_match: assert property (@(posedge clk) disable iff (!rst_n)
    en && cnt == act_q |=> !pwm_q);

  // R4: active compare untouched inside a running period
  a_r4_active_stable: assert property (@(posedge clk) disable iff (!rst_n)
    en && !wrap |=> act_q == $past(act_q));

  // R6: index steps by one at each boundary
  a_r6_idx_step: assert property (@(posedge clk) disable iff (!rst_n)
    en && wrap |=> idx_q == IDX_W'($past(idx_q) + 1'b1));

  // R7: paused generator keeps its index and drives low
  a_r7_idx_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> idx_q == $past(idx_q));

  a_r7_pwm_off: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> !pwm_q);

endmodule

// File: rtl/sinpwm_gen.sv
module sinpwm_gen #(
  parameter int CNT_W = 8,
  parameter int IDX_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  output logic             pwm_o,
  output logic             period_stb_o,
  output logic [IDX_W-1:0] sample_idx_o
);

  logic             srst_n;
  logic [CNT_W-1:0] cnt;
  logic             wrap;
  logic [IDX_W-1:0] rom_a_addr, rom_b_addr;
  logic [CNT_W-1:0] rom_a_data, rom_b_data;

  sinpwm_rst_sync #(.STAGES(2)) u_rst (
    .clk      (clk),
    .arst_n   (rst_n),
    .srst_n_o (srst_n)
  );

  sinpwm_period_ctr #(.CNT_W(CNT_W)) u_ctr (
    .clk    (clk),
    .rst_n  (srst_n),
    .en     (en),
    .cnt_o  (cnt),
    .wrap_o (wrap)
  );

  sinpwm_sine_rom #(.IDX_W(IDX_W), .SMP_W(CNT_W)) u_rom (
    .addr_a (rom_a_addr),
    .addr_b (rom_b_addr),
    .data_a (rom_a_data),
    .data_b (rom_b_data)
  );

  sinpwm_duty_ctl #(.CNT_W(CNT_W), .IDX_W(IDX_W)) u_duty (
    .clk        (clk),
    .rst_n      (srst_n),
    .en         (en),
    .cnt        (cnt),
    .wrap       (wrap),
    .rom_a_data (rom_a_data),
    .rom_b_data (rom_b_data),
    .rom_a_addr (rom_a_addr),
    .rom_b_addr (rom_b_addr),
    .idx_o      (sample_idx_o),
    .pwm_o      (pwm_o)
  );

  assign period_stb_o = wrap;

  // R1: strobe never raised while paused
  a_r1_stb_gated: assert property (@(posedge clk) disable iff (!srst_n)
    !en |-> !period_stb_o);

endmodule

// File: tb/sim_sinpwm_gen.sv
module sim_sinpwm_gen;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       en;
  logic       pwm;
  logic       stb;
  logic [7:0] idx;

  int checks = 0;
  int errors = 0;
  int cyc    = 0;
  int ref_tbl [256];

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  sinpwm_gen u0 (
    .clk          (clk),
    .rst_n        (rst_n),
    .en           (en),
    .pwm_o        (pwm),
    .period_stb_o (stb),
    .sample_idx_o (idx)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // R5: entry i = floor(127.5 + 127.5*sin(2*pi*i/256) + 0.5)
  task automatic build_ref();
    for (int i = 0; i < 256; i++) begin
      real v;
      v = 127.5 + 127.5 * $sin(2.0 * 3.14159265358979323846 * real'(i) / 256.0) + 0.5 + 1.0e-9;
      ref_tbl[i] = $rtoi(v);
    end
    check(ref_tbl[0] == 128 && ref_tbl[64] == 255 && ref_tbl[192] == 0,
          "R5 table anchors", ref_tbl[64], 255);
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    en    = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check(pwm == 1'b0, "R9 pwm after reset", pwm, 0);
    check(stb == 1'b0, "R9 strobe after reset", stb, 0);
    check(idx == 8'd0, "R9 index after reset", idx, 0);
  endtask

  // Measures nper periods; fresh=1 when en is raised by this task.
  task automatic t_sweep(input int nper, input bit fresh, input string tag);
    int hi = 0;
    int samp = 0;
    int per = 0;
    int prev_idx = -1;
    int start_idx;
    if (fresh) en = 1'b1;
    @(negedge clk);
    start_idx = idx;
    while (per < nper) begin
      samp++;
      if (pwm) hi++;
      if (idx != start_idx)
        check(1'b0, "R4 index changed mid-period", idx, start_idx);
      if (stb) begin
        int exp_len = (fresh && per == 0) ? 255 : 256;
        check(hi == ref_tbl[idx], $sformatf("R2 %s high time idx %0d", tag, idx), hi, ref_tbl[idx]);
        if (idx == 64)  check(hi == 255, "R3 full-scale entry", hi, 255);
        if (idx == 192) check(hi == 0,   "R3 zero entry", hi, 0);
        if (per == 0 || !fresh)
          check(samp == exp_len, $sformatf("R1 %s period length", tag), samp, exp_len);
        if (prev_idx >= 0)
          check(idx == ((prev_idx + 1) % 256), "R6 index step", idx, (prev_idx + 1) % 256);
        prev_idx = idx;
        hi = 0;
        samp = 0;
        per++;
        @(negedge clk);
        start_idx = idx;
      end else begin
        @(negedge clk);
      end
    end
  endtask

  task automatic t_pause_resume();
    int held;
    repeat (100) @(negedge clk);
    en = 1'b0;
    held = idx;
    for (int k = 0; k < 12; k++) begin
      @(negedge clk);
      check(pwm == 1'b0, "R7 output low while paused", pwm, 0);
      check(stb == 1'b0, "R7 strobe low while paused", stb, 0);
      check(idx == held, "R7 index held", idx, held);
    end
    // R8: restart at count 0 with the held sample
    begin
      int hi = 0;
      int samp = 0;
      en = 1'b1;
      while (samp < 300) begin
        @(negedge clk);
        samp++;
        if (pwm) hi++;
        if (stb) break;
      end
      check(samp == 255, "R8 first strobe after restart", samp, 255);
      check(idx == held, "R8 index after restart", idx, held);
      check(hi == ref_tbl[held], "R8 duty after restart", hi, ref_tbl[held]);
    end
  endtask

  initial begin
    build_ref();
    t_reset();
    t_sweep(260, 1'b1, "sweep");
    t_pause_resume();
    t_sweep(4, 1'b0, "continue");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    wait (cyc >= 190000);
    errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", cyc, 190000);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule